// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers each 32-bit bus address to a downstream target. It holds eight windows. Software programs each one with a power-of-two span, a base, a target identifier and an attribute code, and the first four windows can also carry a replacement (remap) address. Every cycle the block compares the incoming address against all enabled windows at once, combinationally. It then reports which window claimed the address, that window's target and attribute, and the translated address. When no window claims the address, it raises a miss flag.

A window's span is a 16-bit field that counts 64 KB pages. Software fills it with ones from the low end upward. A field of 0x00FF gives a 16 MB window, and a field of all zeros still covers one 64 KB page. Where windows overlap, the lowest-numbered window takes the address. Configuration arrives through a simple write port that addresses one register of one window per cycle.

Top module: `addr_win_decoder`

## Requirements
- R1: A write with `wr_en` high updates the register chosen by `wr_win` and `wr_sel` at the next rising clock edge. The `wr_sel` codes are: 0 = control, 1 = base, 2 = remap low, 3 = remap high. Decode results do not change before that edge.
- R2: The control register fields are: bit 0 = enable, bits 7:4 = target id, bits 15:8 = attribute, bits 31:16 = size. Bits 3:1 are ignored. A hit drives `tgt_id` and `attr_code` from the winning window's fields.
- R3: Let mask = {size, 16'hFFFF}. An enabled window claims the address when (addr & ~mask) equals (base & ~mask). The low 16 bits of base are ignored, and a size of 0 covers exactly 64 KB.
- R4: A window whose enable bit is 0 never claims an address. Reset clears every register, so every address misses after reset.
- R5: For windows 0 to 3, `addr_out` = (remap_lo & ~mask) | (addr & mask) and `addr_out_hi` = remap_hi of the winning window.
- R6: Windows 4 to 7 have no remap registers. Writes with `wr_sel` 2 or 3 to these windows have no effect. A hit in one of them gives `addr_out` = `addr_in` and `addr_out_hi` = 0.
- R7: When several enabled windows claim the address, the lowest-numbered one wins, and `hit_win` gives its index.
- R8: On a miss, `miss` = 1, `hit_win` = 0, `tgt_id` = 0, `attr_code` = 0, `addr_out` = `addr_in` and `addr_out_hi` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Active-low synchronous reset, clears all window registers |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index of the write |
| wr_sel | input | 2 | Register within the window (0 control, 1 base, 2 remap low, 3 remap high) |
| wr_data | input | 32 | Write data |
| addr_in | input | 32 | Address to decode |
| miss | output | 1 | No enabled window claims `addr_in` |
| hit_win | output | 3 | Index of the winning window |
| tgt_id | output | 4 | Target id of the winning window |
| attr_code | output | 8 | Attribute code of the winning window |
| addr_out | output | 32 | Translated address |
| addr_out_hi | output | 32 | Upper address word from the winning window's remap high register |

## Verification
The decode path is combinational, so a bad stored field shows up on the outputs as soon as any address falls inside, or just outside, the affected window. The bench probes both edges of every window and many addresses inside each span, so a wrong mask width, comparator bit or priority order gives a wrong `miss`, `hit_win` or `addr_out` value within the first sweep after configuration. A write that lands one cycle early or late shows up at the single probe placed between the write strobe and its clock edge. Remap writes to windows without remap registers are checked by sweeping those windows after the writes and comparing `addr_out` with the address.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int ADDR_W = 32;
  localparam int PAGE_W = 16;
  localparam int SIZE_W = ADDR_W - PAGE_W;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;
  localparam int NWIN   = 8;
  localparam int NREMAP = 4;

  // control word field positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_TGT_LSB  = 4;
  localparam int CTL_ATTR_LSB = 8;
  localparam int CTL_SIZE_LSB = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_RLO  = 2'd2,
    REG_RHI  = 2'd3
  } reg_sel_e;

  // bits of the address that pass through the window untouched
  function automatic logic [ADDR_W-1:0] span_mask(input logic [SIZE_W-1:0] sz);
    return {sz, {PAGE_W{1'b1}}};
  endfunction

  function automatic logic win_cover(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [SIZE_W-1:0] sz);
    return ((addr ^ base) & ~span_mask(sz)) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] win_xlate(input logic [ADDR_W-1:0] addr,
                                                  input logic [ADDR_W-1:0] rlo,
                                                  input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] m;
    m = span_mask(sz);
    return (rlo & ~m) | (addr & m);
  endfunction
endpackage

// File: rtl/win_regs.sv
module win_regs
  import addr_win_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic              en,
  output logic [TGT_W-1:0]  tgt,
  output logic [ATTR_W-1:0] attr,
  output logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] rlo,
  output logic [ADDR_W-1:0] rhi
);
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^wdata[CTL_TGT_LSB-1:CTL_EN_BIT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      tgt  <= '0;
      attr <= '0;
      size <= '0;
      base <= '0;
    end else if (we) begin
      if (sel == REG_CTRL) begin
        en   <= wdata[CTL_EN_BIT];
        tgt  <= wdata[CTL_TGT_LSB +: TGT_W];
        attr <= wdata[CTL_ATTR_LSB +: ATTR_W];
        size <= wdata[CTL_SIZE_LSB +: SIZE_W];
      end else if (sel == REG_BASE) begin
        base <= wdata;
      end
    end
  end

  generate
    if (HAS_REMAP) begin : g_remap
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo <= '0;
          rhi <= '0;
        end else if (we && sel == REG_RLO) begin
          rlo <= wdata;
        end else if (we && sel == REG_RHI) begin
          rhi <= wdata;
        end
      end
    end else begin : g_no_remap
      assign rlo = '0;
      assign rhi = '0;
    end
  endgenerate

  // control write lands on the very next edge
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == REG_CTRL) |=>
      (en == $past(wdata[CTL_EN_BIT]) && size == $past(wdata[CTL_SIZE_LSB +: SIZE_W])));

  assert_base_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == REG_BASE) |=> (base == $past(wdata)));
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] rlo,
  input  logic [ADDR_W-1:0] rhi,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr,
  output logic [ADDR_W-1:0] xhi
);
  assign hit = en && win_cover(addr, base, size);

  generate
    if (HAS_REMAP) begin : g_xlate
      assign xaddr = win_xlate(addr, rlo, size);
      assign xhi   = rhi;
    end else begin : g_pass
      logic unused_remap;
      assign unused_remap = ^{rlo, rhi};
      assign xaddr = addr;
      assign xhi   = '0;
    end
  endgenerate
endmodule

// File: rtl/win_prio.sv
module win_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit_vec,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  // isolate the lowest set bit
  assign grant = hit_vec & (~hit_vec + 1'b1);
  assign any   = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((hit_vec & (grant - 1'b1)) == '0 && grant[idx]));
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = NWIN,
  parameter int NUM_REMAP = NREMAP,
  localparam int IW = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_win,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              miss,
  output logic [IW-1:0]     hit_win,
  output logic [TGT_W-1:0]  tgt_id,
  output logic [ATTR_W-1:0] attr_code,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] addr_out_hi
);
  logic [NUM_WIN-1:0] en_vec;
  logic [NUM_WIN-1:0] hit_vec;
  logic [NUM_WIN-1:0] grant;
  logic               any_hit;
  logic [IW-1:0]      win_idx;
  logic [TGT_W-1:0]   tgt_a  [NUM_WIN];
  logic [ATTR_W-1:0]  attr_a [NUM_WIN];
  logic [ADDR_W-1:0]  xad_a  [NUM_WIN];
  logic [ADDR_W-1:0]  xhi_a  [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam bit REMAP = (w < NUM_REMAP);
    logic [SIZE_W-1:0] sz;
    logic [ADDR_W-1:0] bs, rl, rh;

    win_regs #(.HAS_REMAP(REMAP)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && wr_win == IW'(w)),
      .sel  (wr_sel),
      .wdata(wr_data),
      .en   (en_vec[w]),
      .tgt  (tgt_a[w]),
      .attr (attr_a[w]),
      .size (sz),
      .base (bs),
      .rlo  (rl),
      .rhi  (rh)
    );

    win_match #(.HAS_REMAP(REMAP)) u_match (
      .addr (addr_in),
      .en   (en_vec[w]),
      .size (sz),
      .base (bs),
      .rlo  (rl),
      .rhi  (rh),
      .hit  (hit_vec[w]),
      .xaddr(xad_a[w]),
      .xhi  (xhi_a[w])
    );
  end

  win_prio #(.N(NUM_WIN)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_vec(hit_vec),
    .grant  (grant),
    .idx    (win_idx),
    .any    (any_hit)
  );

  // one-hot OR mux over the granted window
  always_comb begin
    tgt_id      = '0;
    attr_code   = '0;
    addr_out    = any_hit ? '0 : addr_in;
    addr_out_hi = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (grant[w]) begin
        tgt_id      = tgt_id | tgt_a[w];
        attr_code   = attr_code | attr_a[w];
        addr_out    = addr_out | xad_a[w];
        addr_out_hi = addr_out_hi | xhi_a[w];
      end
    end
  end

  assign miss    = !any_hit;
  assign hit_win = win_idx;

  assert_disabled_never_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~en_vec) == '0);

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (tgt_id == '0 && attr_code == '0 && addr_out == addr_in && hit_win == '0));

  assert_remap_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss && int'(hit_win) >= NUM_REMAP) |-> (addr_out == addr_in && addr_out_hi == '0));
endmodule

// File: tb/addr_win_decoder_bench.sv
module addr_win_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] addr_in = '0;
  logic        miss;
  logic [2:0]  hit_win;
  logic [3:0]  tgt_id;
  logic [7:0]  attr_code;
  logic [31:0] addr_out, addr_out_hi;

  addr_win_decoder u_addr_win_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .addr_in(addr_in), .miss(miss), .hit_win(hit_win),
    .tgt_id(tgt_id), .attr_code(attr_code), .addr_out(addr_out), .addr_out_hi(addr_out_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] sh_ctrl[8], sh_base[8], sh_rlo[8], sh_rhi[8];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, addr_in, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] sz, input logic [7:0] at,
                                      input logic [3:0] tg, input logic en);
    return {sz, at, tg, 3'b101, en}; // spare bits set on purpose (R2: ignored)
  endfunction

  task automatic shadow_clear();
    for (int w = 0; w < 8; w++) begin
      sh_ctrl[w] = '0; sh_base[w] = '0; sh_rlo[w] = '0; sh_rhi[w] = '0;
    end
  endtask

  task automatic wr(input int w, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'(w); wr_sel = 2'(sel); wr_data = d;
    // R6: remap registers exist only in windows 0..3
    case (sel)
      0: sh_ctrl[w] = d;
      1: sh_base[w] = d;
      2: if (w < 4) sh_rlo[w] = d;
      default: if (w < 4) sh_rhi[w] = d;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // compare all outputs against a model built from R2..R8
  task automatic probe(input logic [31:0] a);
    logic        em;
    logic [2:0]  ew;
    logic [3:0]  et;
    logic [7:0]  ea;
    logic [31:0] eo, eh, m;
    @(negedge clk);
    addr_in = a;
    #1;
    em = 1'b1; ew = '0; et = '0; ea = '0; eo = a; eh = '0;
    for (int w = 0; w < 8; w++) begin
      m = {sh_ctrl[w][31:16], 16'hFFFF};
      if (em && sh_ctrl[w][0] && ((a & ~m) == (sh_base[w] & ~m))) begin
        em = 1'b0; ew = 3'(w); et = sh_ctrl[w][7:4]; ea = sh_ctrl[w][15:8];
        if (w < 4) begin
          eo = (sh_rlo[w] & ~m) | (a & m);
          eh = sh_rhi[w];
        end
      end
    end
    chk("R3 miss", {31'b0, miss}, {31'b0, em});
    chk("R7 hit_win", {29'b0, hit_win}, {29'b0, ew});
    chk("R2 tgt_id", {28'b0, tgt_id}, {28'b0, et});
    chk("R2 attr_code", {24'b0, attr_code}, {24'b0, ea});
    chk("R5 addr_out", addr_out, eo);
    chk("R5 addr_out_hi", addr_out_hi, eh);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
  endtask

  task automatic sweep();
    logic [31:0] m, lo;
    for (int w = 0; w < 8; w++) begin
      m  = {sh_ctrl[w][31:16], 16'hFFFF};
      lo = sh_base[w] & ~m;
      probe(lo); probe(lo | m); probe((lo | m) + 32'd1); probe(lo - 32'd1);
      for (int k = 0; k < 24; k++) begin
        step_lfsr();
        probe(lo | (lfsr & m));
      end
    end
    for (int k = 0; k < 300; k++) begin
      step_lfsr();
      probe(lfsr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    shadow_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4, R8: nothing enabled after reset
    probe(32'h0000_0000); probe(32'h9000_1234); probe(32'hFFFF_FFFF);

    // R1: stage window 0 and check that decode waits for the clock edge
    wr(0, 1, 32'h9012_3456);           // base, low 16 bits ignored (R3)
    wr(0, 2, 32'h10AB_CDEF);           // remap low (R5)
    wr(0, 3, 32'h0000_0001);           // remap high
    @(negedge clk);
    wr_en = 1'b1; wr_win = 3'd0; wr_sel = 2'd0; wr_data = ctl(16'h00FF, 8'hE8, 4'h4, 1'b1);
    addr_in = 32'h9055_0000;
    #1;
    chk("R1 pre-edge miss", {31'b0, miss}, 32'd1);
    sh_ctrl[0] = wr_data;
    @(negedge clk);
    wr_en = 1'b0;
    probe(32'h9055_0000);
    chk("R1 post-edge hit_win", {29'b0, hit_win}, 32'd0);
    chk("R1 post-edge tgt", {28'b0, tgt_id}, 32'd4);

    wr(1, 1, 32'hC001_0000); wr(1, 2, 32'hA000_0000);
    wr(1, 0, ctl(16'h0000, 8'h11, 4'h1, 1'b1));      // 64 KB window (R3)
    wr(2, 1, 32'hD800_0000); wr(2, 2, 32'hD800_0000);
    wr(2, 0, ctl(16'h07FF, 8'h22, 4'h2, 1'b1));
    wr(3, 1, 32'hE80C_1234); wr(3, 2, 32'h0004_0000); wr(3, 3, 32'h0000_00FF);
    wr(3, 0, ctl(16'h0003, 8'h33, 4'h3, 1'b1));
    wr(4, 1, 32'hF100_0000);
    wr(4, 0, ctl(16'h000F, 8'h44, 4'h5, 1'b1));
    wr(5, 1, 32'hD800_0000);                          // overlaps window 2 (R7)
    wr(5, 0, ctl(16'h07FF, 8'h55, 4'h6, 1'b1));
    wr(6, 1, 32'h0002_0000);
    wr(6, 0, ctl(16'h0001, 8'h66, 4'h7, 1'b1));
    wr(7, 1, 32'h0000_0000);
    wr(7, 0, ctl(16'hFFFF, 8'h77, 4'h8, 1'b0));      // disabled catch-all (R4)
    sweep();

    // R7: window 2 wins the overlap; R4: after disabling it, window 5 takes it
    probe(32'hD812_3456);
    chk("R7 overlap low wins", {29'b0, hit_win}, 32'd2);
    wr(2, 0, ctl(16'h07FF, 8'h22, 4'h2, 1'b0));
    probe(32'hD812_3456);
    chk("R4 disabled skipped", {29'b0, hit_win}, 32'd5);
    sweep();

    // R6: remap writes to windows 4..7 have no effect
    wr(4, 2, 32'h1234_0000); wr(4, 3, 32'hDEAD_BEEF);
    wr(6, 2, 32'h5555_0000); wr(6, 3, 32'h0000_0007);
    probe(32'hF10A_BCDE);
    chk("R6 pass-through", addr_out, 32'hF10A_BCDE);
    chk("R6 hi zero", addr_out_hi, 32'h0);
    sweep();

    // R3: full-size window 7 catches everything the others miss
    wr(7, 0, ctl(16'hFFFF, 8'h77, 4'h8, 1'b1));
    sweep();

    // R4: reset clears every enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    shadow_clear();
    probe(32'h9055_0000); probe(32'hD812_3456); probe(32'h1357_9BDF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule